// File: doc/BRIEF.md
# Delayed-Transaction Target Controller

This controller sits inside a slow bus target or a bridge. When an initiator addresses it with a command that may be deferred, it captures the request fields and starts the access on a simple backend port. If the backend answers within a short first-phase window, the data phase completes at once. If it does not, the controller ends the data phase with a retry and no data moves. The backend access then finishes inside the target while the bus is free for other traffic, and the result is parked in a one-entry buffer.

When the initiator repeats exactly the same request, the parked result is handed over and the entry is freed. Requests that differ from the parked one are turned away with retry and are not captured. A parked result that is never collected is dropped after a programmable number of clocks, counted from the moment the request was captured, and the controller becomes free again. Memory writes are never deferred. They are accepted at once and forwarded when the entry is free, and refused with retry otherwise.

The bus side sees the decoded address-phase fields, an address-hit flag and the active-low frame and initiator-ready strobes. It drives the active-low target-ready, stop and device-select strobes. Physical bus drivers and parity are outside this block.

Top module: `dt_target_ctrl`

## Requirements
- R1: During and right after reset, trdy_n, stop_n and devsel_n are high (deasserted) and be_req_valid is low.
- R2: An address phase is a cycle with frame_n low that follows a cycle with frame_n and irdy_n both high. For a claimed request, devsel_n is low in the cycle after the address phase. A request captured from an idle controller is issued on the backend exactly once. be_req_valid stays high with stable fields until be_req_ready.
- R3: If the backend completes a captured request within FIRST_LIMIT (default 16) clocks of the address phase, the first data phase ends with trdy_n and stop_n both low (a single-phase disconnect), and rd_data carries the backend read data.
- R4: If the result is not available within FIRST_LIMIT clocks, the controller signals retry: stop_n low, trdy_n high, devsel_n low, and no data moves.
- R5: A repeat whose address, command and byte enables all equal the parked request is answered with trdy_n low and the buffered read data, with no new backend request. After that transfer the entry is free, so the next eligible request is captured and issued again.
- R6: For the write commands 0011 and 1011, a repeat also needs equal write data. A repeat that differs in write data or in byte enables is answered with retry and does not complete.
- R7: While a request is parked, an eligible request that does not match it is answered with retry and is neither captured nor issued.
- R8: A matching repeat that arrives before the backend has completed is answered with retry. It does not restart the discard timer.
- R9: A parked result is kept until DISCARD_CLKS (default 32768) clocks after its capture. It is then dropped, and the next request is captured as new. A repeat that arrives before that point still gets the buffered data.
- R10: Only the commands 0000, 0010, 0011, 0110, 1110, 1100, 1010 and 1011 are deferred. The commands 0001, 0100, 0101, 1000, 1001, 1101 and 1111 are not claimed: devsel_n stays high and no backend request is made.
- R11: A memory write (command 0111) with a free entry completes in its first data phase with trdy_n and stop_n low, and it is forwarded once to the backend. While a request is parked or a write is in flight, a memory write is refused with retry.
- R12: An address phase with addr_hit low is not claimed: devsel_n stays high and no backend request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Initiator frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| addr_hit | input | 1 | Address decodes to this target (valid in the address phase) |
| bus_addr | input | ADDR_W | Decoded address of the address phase |
| bus_cmd | input | 4 | Command code of the address phase |
| bus_be_n | input | 4 | Byte enables, active low |
| bus_wdata | input | DATA_W | Write data presented with the request |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop, active low |
| devsel_n | output | 1 | Device select, active low |
| rd_data | output | DATA_W | Read data, valid while trdy_n is low |
| be_req_valid | output | 1 | Backend request valid |
| be_req_ready | input | 1 | Backend accepts the request |
| be_req_addr | output | ADDR_W | Backend request address |
| be_req_cmd | output | 4 | Backend request command |
| be_req_be_n | output | 4 | Backend request byte enables |
| be_req_wdata | output | DATA_W | Backend request write data |
| be_done | input | 1 | One-cycle completion pulse from the backend |
| be_rdata | input | DATA_W | Backend read data, valid with be_done |

## Verification
The assertions check on every cycle that a backend request holds until it is accepted. They also check that nothing is captured while the entry is occupied, that a buffered result is handed out only when one is parked, that a dropped entry is free on the next cycle, and that device select is never held without target ready or stop for more than the first-phase window. Whether a request is answered with data or retry, which commands are claimed, that write data takes part in matching, and how the discard window is measured against the capture time only show up in the bench's scenarios. The bench tells these apart by the outcome at the ports and by how many backend requests its model has counted.

// File: rtl/dt_pkg.sv
package dt_pkg;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;

  localparam logic [3:0] CMD_INTA = 4'b0000;
  localparam logic [3:0] CMD_IOR  = 4'b0010;
  localparam logic [3:0] CMD_IOW  = 4'b0011;
  localparam logic [3:0] CMD_MR   = 4'b0110;
  localparam logic [3:0] CMD_MW   = 4'b0111;
  localparam logic [3:0] CMD_CFGR = 4'b1010;
  localparam logic [3:0] CMD_CFGW = 4'b1011;
  localparam logic [3:0] CMD_MRM  = 4'b1100;
  localparam logic [3:0] CMD_MRL  = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_DATA, ST_ACCEPT, ST_STOP
  } bus_st_e;

  typedef enum logic [1:0] {
    E_EMPTY, E_ISSUE, E_WAIT, E_READY
  } ent_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [3:0]        cmd;
    logic [3:0]        be_n;
    logic [DATA_W-1:0] wdata;
  } req_t;

  function automatic logic may_defer(input logic [3:0] c);
    case (c)
      CMD_INTA, CMD_IOR, CMD_IOW, CMD_MR,
      CMD_MRL, CMD_MRM, CMD_CFGR, CMD_CFGW: may_defer = 1'b1;
      default:                              may_defer = 1'b0;
    endcase
  endfunction

  function automatic logic carries_wdata(input logic [3:0] c);
    carries_wdata = (c == CMD_IOW) || (c == CMD_CFGW);
  endfunction

  function automatic logic same_req(input req_t a, input req_t b);
    same_req = (a.addr == b.addr) && (a.cmd == b.cmd) && (a.be_n == b.be_n) &&
               (!carries_wdata(a.cmd) || (a.wdata == b.wdata));
  endfunction
endpackage

// File: rtl/dt_phase_detect.sv
module dt_phase_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic addr_phase
);
  logic was_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) was_idle <= 1'b1;
    else        was_idle <= frame_n & irdy_n;
  end

  assign addr_phase = !frame_n && was_idle;

  a_r2_phase_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> $past(frame_n) && $past(irdy_n));
endmodule

// File: rtl/dt_entry.sv
module dt_entry
  import dt_pkg::*;
#(
  parameter int DISCARD_CLKS = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_i,
  input  logic              posted_i,
  input  req_t              req_i,
  input  logic              consume_i,
  input  logic              hold_i,
  input  logic              be_req_ready,
  input  logic              be_done,
  input  logic [DATA_W-1:0] be_rdata,
  output logic              busy_o,
  output logic              ready_o,
  output logic              match_o,
  output logic              be_req_valid,
  output req_t              be_req,
  output logic [DATA_W-1:0] rdata_o,
  output logic              discard_o
);
  localparam int TW = $clog2(DISCARD_CLKS + 1);
  localparam logic [TW-1:0] T_LIMIT = TW'(DISCARD_CLKS);

  ent_st_e           st;
  req_t              held;
  logic              posted_q;
  logic [TW-1:0]     tmr;
  logic [DATA_W-1:0] rbuf;
  logic              expired;

  assign expired   = (tmr == T_LIMIT);
  assign busy_o    = (st != E_EMPTY);
  assign ready_o   = (st == E_READY);
  assign match_o   = busy_o && !posted_q && same_req(held, req_i);
  assign discard_o = ready_o && expired && !hold_i && !consume_i;
  assign be_req_valid = (st == E_ISSUE);
  assign be_req    = held;
  assign rdata_o   = rbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= E_EMPTY;
      held     <= '0;
      posted_q <= 1'b0;
      tmr      <= '0;
      rbuf     <= '0;
    end else begin
      if (busy_o && !posted_q && !expired) tmr <= tmr + 1'b1;
      case (st)
        E_EMPTY: if (latch_i) begin
          held     <= req_i;
          posted_q <= posted_i;
          tmr      <= '0;
          st       <= E_ISSUE;
        end
        E_ISSUE: if (be_req_ready) st <= E_WAIT;
        E_WAIT: if (be_done) begin
          if (posted_q) st <= E_EMPTY;
          else begin
            rbuf <= be_rdata;
            st   <= E_READY;
          end
        end
        E_READY: if (consume_i || discard_o) st <= E_EMPTY;
        default: st <= E_EMPTY;
      endcase
    end
  end

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    be_req_valid && !be_req_ready |=> be_req_valid && $stable(be_req));
  a_r7_no_latch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |-> !busy_o);
  a_r5_consume_has_result: assert property (@(posedge clk) disable iff (!rst_n)
    consume_i |-> ready_o);
  a_r9_discard_frees: assert property (@(posedge clk) disable iff (!rst_n)
    discard_o |=> !busy_o);
endmodule

// File: rtl/dt_bus_fsm.sv
module dt_bus_fsm
  import dt_pkg::*;
#(
  parameter int FIRST_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_phase,
  input  logic       addr_hit,
  input  logic [3:0] cmd,
  input  logic       irdy_n,
  input  logic       ent_busy,
  input  logic       ent_ready,
  input  logic       ent_match,
  output logic       latch_o,
  output logic       posted_o,
  output logic       consume_o,
  output logic       hold_o,
  output logic       devsel_n,
  output logic       trdy_n,
  output logic       stop_n
);
  localparam int CW = (FIRST_LIMIT > 1) ? $clog2(FIRST_LIMIT) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(FIRST_LIMIT - 1);
  localparam int RW = $clog2(FIRST_LIMIT + 1);

  bus_st_e       st, st_nx;
  logic [CW-1:0] cnt;
  logic          claim, is_mw;

  assign is_mw     = (cmd == CMD_MW);
  assign claim     = (st == ST_IDLE) && addr_phase && addr_hit;
  assign latch_o   = claim && !ent_busy && (may_defer(cmd) || is_mw);
  assign posted_o  = is_mw;
  assign hold_o    = (st == ST_DATA);
  assign consume_o = (st == ST_DATA) && !irdy_n;

  assign devsel_n = (st == ST_IDLE);
  assign trdy_n   = !((st == ST_DATA) || (st == ST_ACCEPT));
  assign stop_n   = !((st == ST_DATA) || (st == ST_ACCEPT) || (st == ST_STOP));

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (claim) begin
        if (may_defer(cmd)) begin
          if (!ent_busy)                   st_nx = ST_FIRST;
          else if (ent_match && ent_ready) st_nx = ST_DATA;
          else                             st_nx = ST_STOP;
        end else if (is_mw) begin
          st_nx = ent_busy ? ST_STOP : ST_ACCEPT;
        end
      end
      ST_FIRST: begin
        if (ent_ready)          st_nx = ST_DATA;
        else if (cnt == C_LAST) st_nx = ST_STOP;
      end
      ST_DATA, ST_ACCEPT, ST_STOP: if (!irdy_n) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= (st == ST_FIRST) ? cnt + 1'b1 : '0;
    end
  end

  logic [RW-1:0] wait_run;
  always_ff @(posedge clk) begin
    if (!rst_n) wait_run <= '0;
    else if (!devsel_n && trdy_n && stop_n) wait_run <= wait_run + 1'b1;
    else wait_run <= '0;
  end

  a_r4_first_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && trdy_n && stop_n) |-> (wait_run < RW'(FIRST_LIMIT)));
  a_r10_claim_only_known: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(may_defer(cmd) || is_mw));
endmodule

// File: rtl/dt_target_ctrl.sv
module dt_target_ctrl
  import dt_pkg::*;
#(
  parameter int FIRST_LIMIT  = 16,
  parameter int DISCARD_CLKS = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              addr_hit,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_cmd,
  input  logic [3:0]        bus_be_n,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              devsel_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              be_req_valid,
  input  logic              be_req_ready,
  output logic [ADDR_W-1:0] be_req_addr,
  output logic [3:0]        be_req_cmd,
  output logic [3:0]        be_req_be_n,
  output logic [DATA_W-1:0] be_req_wdata,
  input  logic              be_done,
  input  logic [DATA_W-1:0] be_rdata
);
  logic addr_phase, latch, posted, consume, hold;
  logic ent_busy, ent_ready, ent_match, discard_evt;
  req_t bus_req, out_req;

  assign bus_req = '{addr: bus_addr, cmd: bus_cmd, be_n: bus_be_n, wdata: bus_wdata};
  assign be_req_addr  = out_req.addr;
  assign be_req_cmd   = out_req.cmd;
  assign be_req_be_n  = out_req.be_n;
  assign be_req_wdata = out_req.wdata;

  dt_phase_detect u_phase (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .addr_phase(addr_phase)
  );

  dt_bus_fsm #(.FIRST_LIMIT(FIRST_LIMIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .addr_hit(addr_hit),
    .cmd(bus_cmd), .irdy_n(irdy_n), .ent_busy(ent_busy), .ent_ready(ent_ready),
    .ent_match(ent_match), .latch_o(latch), .posted_o(posted),
    .consume_o(consume), .hold_o(hold), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n)
  );

  dt_entry #(.DISCARD_CLKS(DISCARD_CLKS)) u_entry (
    .clk(clk), .rst_n(rst_n), .latch_i(latch), .posted_i(posted),
    .req_i(bus_req), .consume_i(consume), .hold_i(hold),
    .be_req_ready(be_req_ready), .be_done(be_done), .be_rdata(be_rdata),
    .busy_o(ent_busy), .ready_o(ent_ready), .match_o(ent_match),
    .be_req_valid(be_req_valid), .be_req(out_req), .rdata_o(rd_data),
    .discard_o(discard_evt)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> devsel_n && trdy_n && stop_n && !be_req_valid);
  a_r12_no_claim_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !addr_hit && devsel_n) |=> devsel_n && !$rose(be_req_valid));
endmodule

// File: tb/tb_dt_target_ctrl.sv
module tb_dt_target_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DISC = 32768;
  localparam int RES_NONE = 0, RES_DATA = 1, RES_RETRY = 2, RES_BAD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, addr_hit = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [3:0]  bus_cmd = '0, bus_be_n = '0;
  logic trdy_n, stop_n, devsel_n;
  logic [31:0] rd_data;
  logic be_req_valid, be_req_ready = 1'b1;
  logic [31:0] be_req_addr, be_req_wdata;
  logic [3:0]  be_req_cmd, be_req_be_n;
  logic be_done = 1'b0;
  logic [31:0] be_rdata = '0;

  int checks = 0, errors = 0, cyc = 0, hs = 0, lat = 3, cd = 0;
  logic [31:0] pend_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dt_target_ctrl dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .addr_hit(addr_hit), .bus_addr(bus_addr), .bus_cmd(bus_cmd),
    .bus_be_n(bus_be_n), .bus_wdata(bus_wdata), .trdy_n(trdy_n),
    .stop_n(stop_n), .devsel_n(devsel_n), .rd_data(rd_data),
    .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
    .be_req_addr(be_req_addr), .be_req_cmd(be_req_cmd),
    .be_req_be_n(be_req_be_n), .be_req_wdata(be_req_wdata),
    .be_done(be_done), .be_rdata(be_rdata)
  );

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  // Backend model: accepts at once, completes lat cycles later.
  always @(negedge clk) begin
    if (be_done) be_done = 1'b0;
    if (cd > 0) begin
      cd = cd - 1;
      if (cd == 0) begin
        be_done  = 1'b1;
        be_rdata = model_rd(pend_addr);
      end
    end
    if (rst_n && be_req_valid) begin
      hs = hs + 1;
      cd = lat;
      pend_addr = be_req_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_txn(input logic [3:0] c, input logic [31:0] a,
                         input logic [3:0] be, input logic [31:0] wd, input logic hit,
                         output int res, output logic [31:0] rd,
                         output logic dev1, output int acyc);
    @(negedge clk);
    frame_n = 1'b0; addr_hit = hit; bus_cmd = c; bus_addr = a;
    bus_be_n = be; bus_wdata = wd;
    acyc = cyc + 1;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; addr_hit = 1'b0;
    dev1 = devsel_n;
    res = RES_NONE; rd = '0;
    for (int i = 0; i < 40; i++) begin
      if (!trdy_n) begin
        res = devsel_n ? RES_BAD : RES_DATA; rd = rd_data; break;
      end
      if (!stop_n) begin
        res = devsel_n ? RES_BAD : RES_RETRY; break;
      end
      @(negedge clk);
    end
    if (res != RES_NONE) @(negedge clk);
    irdy_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c - 1) @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        hit;
    logic [1:0]  res;
    logic        issue;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'b0110, 32'h0000_1000, 32'h0,         1'b1, 2'd1, 1'b1}, // R3 memory read
    '{4'b0010, 32'h0000_0040, 32'h0,         1'b1, 2'd1, 1'b1}, // R3 I/O read
    '{4'b0011, 32'h0000_0044, 32'h1111_2222, 1'b1, 2'd1, 1'b1}, // R3 I/O write
    '{4'b1010, 32'h0000_0810, 32'h0,         1'b1, 2'd1, 1'b1}, // R3 config read
    '{4'b1011, 32'h0000_0814, 32'h3333_4444, 1'b1, 2'd1, 1'b1}, // R3 config write
    '{4'b1110, 32'h0000_2000, 32'h0,         1'b1, 2'd1, 1'b1}, // R10 read line
    '{4'b1100, 32'h0000_3000, 32'h0,         1'b1, 2'd1, 1'b1}, // R10 read multiple
    '{4'b0000, 32'h0000_0000, 32'h0,         1'b1, 2'd1, 1'b1}, // R10 int ack
    '{4'b0001, 32'h0000_0100, 32'h0,         1'b1, 2'd0, 1'b0}, // R10 special
    '{4'b0100, 32'h0000_0104, 32'h0,         1'b1, 2'd0, 1'b0}, // R10 reserved
    '{4'b1111, 32'h0000_0108, 32'h0,         1'b1, 2'd0, 1'b0}, // R10 write+inval
    '{4'b1101, 32'h0000_010C, 32'h0,         1'b1, 2'd0, 1'b0}, // R10 dual addr
    '{4'b0111, 32'h0000_4000, 32'h5555_6666, 1'b1, 2'd1, 1'b1}, // R11 memory write
    '{4'b0110, 32'h0000_5000, 32'h0,         1'b0, 2'd0, 1'b0}  // R12 miss
  };

  initial begin
    int res, acyc, h0, la, lb;
    logic [31:0] rd;
    logic dev1;

    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !be_req_valid, "R1 reset outputs",
        {devsel_n, trdy_n, stop_n, be_req_valid}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !be_req_valid, "R1 after reset",
        {devsel_n, trdy_n, stop_n, be_req_valid}, 4'b1110);

    lat = 3;
    for (int v = 0; v < NV; v++) begin
      h0 = hs;
      bus_txn(VECS[v].cmd, VECS[v].addr, 4'h0, VECS[v].wd, VECS[v].hit, res, rd, dev1, acyc);
      chk(res == int'(VECS[v].res), $sformatf("R3/R10/R11/R12 vec %0d result", v),
          res, VECS[v].res);
      chk(hs - h0 == int'(VECS[v].issue), $sformatf("R2 vec %0d backend issues", v),
          hs - h0, VECS[v].issue);
      chk(dev1 == !VECS[v].res[0], $sformatf("R2 vec %0d devsel timing", v),
          dev1, !VECS[v].res[0]);
      if (VECS[v].res == 2'd1 && VECS[v].cmd != 4'b0111 && !VECS[v].cmd[0])
        chk(rd == model_rd(VECS[v].addr), $sformatf("R3 vec %0d read data", v),
            rd, model_rd(VECS[v].addr));
      repeat (10) @(negedge clk);
    end

    // Slow backend: retry, pending behaviour, later collection (R4 R5 R7 R8 R11)
    lat = 60; h0 = hs;
    bus_txn(4'b0110, 32'h0000_A000, 4'h0, 32'h0, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_RETRY, "R4 slow read retried", res, RES_RETRY);
    chk(hs - h0 == 1, "R2 slow read issued once", hs - h0, 1);
    bus_txn(4'b0110, 32'h0000_A000, 4'h0, 32'h0, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_RETRY, "R8 early repeat retried", res, RES_RETRY);
    bus_txn(4'b0110, 32'h0000_B000, 4'h0, 32'h0, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_RETRY, "R7 other request retried", res, RES_RETRY);
    bus_txn(4'b0110, 32'h0000_A000, 4'h3, 32'h0, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_RETRY, "R7 byte-enable mismatch retried", res, RES_RETRY);
    bus_txn(4'b0111, 32'h0000_C000, 4'h0, 32'h77, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_RETRY, "R11 memory write refused while pending", res, RES_RETRY);
    chk(hs - h0 == 1, "R7 no capture while pending", hs - h0, 1);
    repeat (60) @(negedge clk);
    bus_txn(4'b0110, 32'h0000_A000, 4'h0, 32'h0, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_DATA, "R5 repeat completes", res, RES_DATA);
    chk(rd == model_rd(32'h0000_A000), "R5 buffered data", rd, model_rd(32'h0000_A000));
    chk(hs - h0 == 1, "R5 no new backend request", hs - h0, 1);
    lat = 3;
    bus_txn(4'b0110, 32'h0000_B000, 4'h0, 32'h0, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_DATA && hs - h0 == 2, "R5 entry freed after completion",
        hs - h0, 2);

    // Write data takes part in matching (R6)
    lat = 60; h0 = hs;
    bus_txn(4'b0011, 32'h0000_0050, 4'h0, 32'hCAFE_0001, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_RETRY, "R6 slow write retried", res, RES_RETRY);
    repeat (70) @(negedge clk);
    bus_txn(4'b0011, 32'h0000_0050, 4'h0, 32'hCAFE_0002, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_RETRY, "R6 write data mismatch retried", res, RES_RETRY);
    bus_txn(4'b0011, 32'h0000_0050, 4'h1, 32'hCAFE_0001, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_RETRY, "R6 byte-enable mismatch retried", res, RES_RETRY);
    bus_txn(4'b0011, 32'h0000_0050, 4'h0, 32'hCAFE_0001, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_DATA && hs - h0 == 1, "R6 exact write repeat completes", res, RES_DATA);

    // Discard window kept just inside the limit (R9)
    h0 = hs;
    bus_txn(4'b0010, 32'h0000_0060, 4'h0, 32'h0, 1'b1, res, rd, dev1, la);
    chk(res == RES_RETRY, "R9 first access retried", res, RES_RETRY);
    wait_until(la + DISC - 40);
    bus_txn(4'b0010, 32'h0000_0060, 4'h0, 32'h0, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_DATA && rd == model_rd(32'h0000_0060), "R9 kept before limit",
        rd, model_rd(32'h0000_0060));
    chk(hs - h0 == 1, "R9 no reissue before limit", hs - h0, 1);

    // Discard after the limit, timer not restarted by early repeat (R8 R9)
    h0 = hs;
    bus_txn(4'b0010, 32'h0000_0070, 4'h0, 32'h0, 1'b1, res, rd, dev1, lb);
    chk(res == RES_RETRY, "R8 access retried", res, RES_RETRY);
    bus_txn(4'b0010, 32'h0000_0070, 4'h0, 32'h0, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_RETRY, "R8 early repeat retried", res, RES_RETRY);
    wait_until(lb + DISC + 4);
    bus_txn(4'b0010, 32'h0000_0070, 4'h0, 32'h0, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_RETRY, "R8 timer counts from capture", res, RES_RETRY);
    chk(hs - h0 == 2, "R9 discarded then recaptured", hs - h0, 2);
    repeat (70) @(negedge clk);
    bus_txn(4'b0010, 32'h0000_0070, 4'h0, 32'h0, 1'b1, res, rd, dev1, acyc);
    chk(res == RES_DATA, "R9 recaptured request completes", res, RES_DATA);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule